// File: doc/BRIEF.md
# Periodic Thermistor Scan Sequencer

This block decides when the thermistor bias supply is switched on and turns a digitized comparator result into latched over-temperature flags. When it is left in its default state it runs a fixed duty cycle. The bias is switched on for a short window at the start of each period and is off for the rest of that period. The block counts a millisecond tick, so the scan keeps running while the host controller sleeps. Two host requests can also keep the bias on: a force-on bit, and selection of the external-temperature code on the analog output selector. All three requests are ORed together. The bias is held off while the device sleeps.

Each time the bias goes from off to on, the comparator input is ignored until a settling time has elapsed. After that, a fail from the comparator sets a sticky external flag. The comparator reports a fail when the sensor voltage is below one-thirteenth of the bias. A status read clears this flag only if the most recent evaluated comparison was a pass. A second sticky flag reports internal over-temperature. It is set only after the internal hot condition has lasted without a break for a qualification delay.

Top module: `therm_scan`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both flags read 0. The scan phase starts at the beginning of its on-window, so with the device awake and the scan enabled the bias is on straight after reset.
- R2: With only the automatic scan requesting, the bias is on for ON_MS ticks and off for PERIOD_MS-ON_MS ticks, and this repeats (defaults 5 and 640).
- R3: While `auto_off` is 1 the automatic request is absent and the phase is held at its start. When `auto_off` returns to 0, a fresh on-window begins.
- R4: While `force_on` is 1 and the device is awake, the bias is on whatever the other inputs are.
- R5: While `ao_sel` equals 4'b1000 and the device is awake, the bias is on. Other `ao_sel` codes have no effect on the bias.
- R6: While `sleep` is 1 the bias is off, and the scan phase returns to the start of its on-window.
- R7: After each off-to-on transition of the bias, `ext_fail` is ignored until SETTLE_MS ticks have been counted with the bias still on (default 1). Requests that overlap while the bias is already on do not restart this count.
- R8: A fail seen after settling sets `ext_ot`. The flag stays at 1 until it is cleared as described in R9.
- R9: A `rd_clr` pulse clears `ext_ot` only when the most recent evaluated comparison (the current one if the bias has settled, otherwise the last one taken) was a pass.
- R10: `int_ot` is set once `int_hot` has been high for INT_DELAY_MS consecutive ticks (default 128). A low cycle on `int_hot` restarts the count.
- R11: `int_ot` stays at 1 until a `rd_clr` arrives while the internal condition is not qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sleep | input | 1 | Device asleep or powered down |
| auto_off | input | 1 | Disables the periodic scan |
| force_on | input | 1 | Keeps the bias on continuously |
| ao_sel | input | 4 | Analog output select code; 4'b1000 is external temperature |
| ext_fail | input | 1 | Comparator: sensor below bias/13 |
| int_hot | input | 1 | Internal over-temperature condition |
| rd_clr | input | 1 | Status read strobe (clear-on-read) |
| bias_en | output | 1 | Thermistor bias enable |
| ext_ot | output | 1 | Sticky external over-temperature flag |
| int_ot | output | 1 | Sticky internal over-temperature flag |

## Verification
The two functions that can land in the same cycle are the setting of a flag by a fresh fail (or by qualification) and a status read that tries to clear that flag. The bench drives `rd_clr` at random, and also in a targeted case while the comparator is still failing after settling. In that case the set must win, because the latest evaluation is a fail. The bench also checks that a read taken while the bias is off is judged against the last settled comparison and not against the live comparator input.

// File: rtl/therm_scan.sv
module therm_scan #(
  parameter int PERIOD_MS    = 640,
  parameter int ON_MS        = 5,
  parameter int SETTLE_MS    = 1,
  parameter int INT_DELAY_MS = 128,
  parameter logic [3:0] SEL_EXT = 4'b1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       sleep,
  input  logic       auto_off,
  input  logic       force_on,
  input  logic [3:0] ao_sel,
  input  logic       ext_fail,
  input  logic       int_hot,
  input  logic       rd_clr,
  output logic       bias_en,
  output logic       ext_ot,
  output logic       int_ot
);
  localparam int PW = $clog2(PERIOD_MS);
  localparam int SW = $clog2(SETTLE_MS + 1);
  localparam int IW = $clog2(INT_DELAY_MS + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_MS - 1);
  localparam logic [PW-1:0] PH_ON   = PW'(ON_MS);
  localparam logic [SW-1:0] ST_DONE = SW'(SETTLE_MS);
  localparam logic [IW-1:0] IN_DONE = IW'(INT_DELAY_MS);

  logic [PW-1:0] phase;
  logic [SW-1:0] settle;
  logic [IW-1:0] icnt;
  logic          bias_q, last_fail;

  wire scan_run = !sleep && !auto_off;
  wire auto_req = scan_run && (phase < PH_ON);
  wire sel_req  = (ao_sel == SEL_EXT);
  assign bias_en = !sleep && (force_on || sel_req || auto_req);

  wire armed    = bias_en && bias_q && (settle == ST_DONE);
  wire cur_fail = armed ? ext_fail : last_fail;
  wire int_now  = int_hot && (icnt == IN_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!scan_run) begin
      phase <= '0;
    end else if (ms_tick) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_q    <= 1'b0;
      settle    <= '0;
      last_fail <= 1'b0;
      ext_ot    <= 1'b0;
    end else begin
      bias_q <= bias_en;
      if (bias_en && !bias_q)
        settle <= '0;
      else if (bias_en && ms_tick && settle != ST_DONE)
        settle <= settle + 1'b1;
      if (armed)
        last_fail <= ext_fail;
      if (armed && ext_fail)
        ext_ot <= 1'b1;
      else if (rd_clr && !cur_fail)
        ext_ot <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt   <= '0;
      int_ot <= 1'b0;
    end else begin
      if (!int_hot)
        icnt <= '0;
      else if (ms_tick && icnt != IN_DONE)
        icnt <= icnt + 1'b1;
      if (int_now)
        int_ot <= 1'b1;
      else if (rd_clr)
        int_ot <= 1'b0;
    end
  end
endmodule

// File: rtl/therm_scan_chk.sv
module therm_scan_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic force_on,
  input logic ext_fail,
  input logic int_hot,
  input logic rd_clr,
  input logic bias_en,
  input logic ext_ot,
  input logic int_ot
);
  p_sleep_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !bias_en);
  p_force_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_on && !sleep) |-> bias_en);
  p_ext_set_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ot) |-> $past(ext_fail && bias_en));
  p_ext_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ot) |-> $past(bias_en, 2));
  p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ot) |-> $past(rd_clr));
  p_int_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ot) |-> $past(int_hot));
  p_int_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_ot) |-> $past(rd_clr));
endmodule

bind therm_scan therm_scan_chk chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .force_on(force_on),
  .ext_fail(ext_fail), .int_hot(int_hot), .rd_clr(rd_clr),
  .bias_en(bias_en), .ext_ot(ext_ot), .int_ot(int_ot)
);

// File: tb/therm_scan_test.sv
`timescale 1ns/1ps
module therm_scan_test;
  localparam int PERIOD = 640, ON = 5, SETTLE = 1, IDLY = 128;

  logic clk = 0, rst_n = 0;
  logic ms_tick = 0, sleep = 0, auto_off = 0, force_on = 0;
  logic [3:0] ao_sel = 4'd0;
  logic ext_fail = 0, int_hot = 0, rd_clr = 0;
  logic bias_en, ext_ot, int_ot;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  therm_scan uut (.clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sleep(sleep),
    .auto_off(auto_off), .force_on(force_on), .ao_sel(ao_sel),
    .ext_fail(ext_fail), .int_hot(int_hot), .rd_clr(rd_clr),
    .bias_en(bias_en), .ext_ot(ext_ot), .int_ot(int_ot));

  int m_phase = 0, m_set = 0, m_icnt = 0;
  bit m_bq = 0, m_live = 0, m_ext = 0, m_int = 0;

  function automatic bit exp_bias();
    bit autoreq = !sleep && !auto_off && (m_phase < ON);
    return !sleep && (force_on || ao_sel == 4'b1000 || autoreq);
  endfunction

  always @(posedge clk) begin
    bit eb, arm, cf;
    if (!rst_n) begin
      m_phase = 0; m_set = 0; m_icnt = 0;
      m_bq = 0; m_live = 0; m_ext = 0; m_int = 0;
    end else begin
      eb  = exp_bias();
      arm = eb && m_bq && (m_set == SETTLE);
      cf  = arm ? ext_fail : m_live;
      if (arm && ext_fail) m_ext = 1;
      else if (rd_clr && !cf) m_ext = 0;
      if (arm) m_live = ext_fail;
      if (eb && !m_bq) m_set = 0;
      else if (eb && ms_tick && m_set < SETTLE) m_set++;
      m_bq = eb;
      if (int_hot && m_icnt == IDLY) m_int = 1;
      else if (rd_clr) m_int = 0;
      if (!int_hot) m_icnt = 0;
      else if (ms_tick && m_icnt < IDLY) m_icnt++;
      if (sleep || auto_off) m_phase = 0;
      else if (ms_tick) m_phase = (m_phase == PERIOD - 1) ? 0 : m_phase + 1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      ms_tick = (cyc % 4 == 0);
      #1;
    end
  endtask

  task automatic cmp_all();
    chk("R2/R3/R4/R5/R6 bias", bias_en, exp_bias());
    chk("R7/R8/R9 ext_ot", ext_ot, m_ext);
    chk("R10/R11 int_ot", int_ot, m_int);
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      cmp_all();
      ms_tick = (cyc % 4 == 0);
      if ($urandom_range(0, 999) < 2) sleep = ~sleep;
      if ($urandom_range(0, 999) < 3) auto_off = ~auto_off;
      if ($urandom_range(0, 999) < 2) force_on = ~force_on;
      if ($urandom_range(0, 999) < 4) ao_sel = ($urandom_range(0, 2) == 0) ? 4'b1000 : 4'($urandom_range(0, 15));
      if ($urandom_range(0, 99) < 3) ext_fail = ~ext_fail;
      if ($urandom_range(0, 999) < 2) int_hot = ~int_hot;
      rd_clr = ($urandom_range(0, 49) == 0);
      #1;
      chk("R2/R3/R4/R5/R6 bias", bias_en, exp_bias());
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    chk("R1 ext_ot in reset", ext_ot, 1'b0);
    chk("R1 int_ot in reset", int_ot, 1'b0);
    rst_n = 1;
    step(1);
    chk("R1 bias on after reset", bias_en, 1'b1);
    chk("R1 ext_ot after reset", ext_ot, 1'b0);

    // R2: one full period of automatic scan, count on-ticks
    begin
      int on_ticks = 0;
      for (int t = 0; t < PERIOD; t++) begin
        step(4);
        if (bias_en) on_ticks++;
        cmp_all();
      end
      chk("R2 on-window ticks", on_ticks == ON, 1'b1);
    end

    // R3: auto_off holds bias off
    auto_off = 1; step(1);
    chk("R3 auto_off bias off", bias_en, 1'b0);
    step(40); chk("R3 stays off", bias_en, 1'b0);
    auto_off = 0; step(1);
    chk("R3 fresh window on release", bias_en, 1'b1);
    auto_off = 1; step(1);

    // R5: other select codes do nothing, 1000 turns bias on
    ao_sel = 4'b1001; step(1); chk("R5 other code no bias", bias_en, 1'b0);
    ao_sel = 4'b1000; step(1); chk("R5 ext select bias on", bias_en, 1'b1);

    // R7/R8: fail during settling ignored, then latched
    ext_fail = 1;
    chk("R7 ignored at turn-on", ext_ot, 1'b0);
    while (cyc % 4 != 3) step(1);
    step(1); chk("R7 ignored before settle tick", ext_ot, m_ext);
    step(1); chk("R7 not set within settling", ext_ot, 1'b0);
    force_on = 1;
    step(4); chk("R8 set after settling", ext_ot, 1'b1);
    ao_sel = 4'd0; step(1); chk("R7 overlap keeps armed", ext_ot, 1'b1);

    // R9: read while still failing keeps flag; set wins
    rd_clr = 1; step(1); rd_clr = 0; step(1);
    chk("R9 read during fail keeps flag", ext_ot, 1'b1);
    ext_fail = 0; step(2);
    force_on = 0; step(1);
    ext_fail = 1; step(1);
    chk("R9 bias off for stale read", bias_en, 1'b0);
    rd_clr = 1; step(1); rd_clr = 0; step(1);
    chk("R9 read uses last settled pass", ext_ot, 1'b0);
    ext_fail = 0;

    // R4 and R6
    force_on = 1; step(1); chk("R4 force on", bias_en, 1'b1);
    sleep = 1; step(1); chk("R6 sleep overrides", bias_en, 1'b0);
    sleep = 0; force_on = 0; auto_off = 0; step(1);
    chk("R6 phase restarted after sleep", bias_en, 1'b1);

    // R10/R11: qualification delay
    int_hot = 1;
    step(4 * (IDLY - 1)); chk("R10 not yet qualified", int_ot, 1'b0);
    step(8); chk("R10 qualified", int_ot, 1'b1);
    rd_clr = 1; step(1); rd_clr = 0; step(1);
    chk("R11 read while hot keeps", int_ot, 1'b1);
    int_hot = 0; step(2);
    rd_clr = 1; step(1); rd_clr = 0; step(1);
    chk("R11 read clears", int_ot, 1'b0);
    int_hot = 1; step(4 * 100); int_hot = 0; step(1); int_hot = 1;
    step(4 * 100); chk("R10 break restarts count", int_ot, 1'b0);
    int_hot = 0;

    run_random(90000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule